// File: doc/BRIEF.md
# Alert Latch and Response Arbiter

This block gathers interrupt causes for a small bus-attached I/O expander and holds them on an active-low open-drain alert line. A cause is a change of level on any of the general-purpose pin inputs whose mask bit is clear, or a thermal fault. The mask set comes from the normal control register or the suspend control register, depending on the suspend select input. After the alert is raised it stays raised, even if the cause goes away. It is released only when the host reads the shared alert-response address and this device places its whole own address on the bus without losing wired-AND arbitration.

The block does not sample the serial wires itself. It sits beside the slave's bit engine. That engine supplies one-cycle strobes for start, stop, SCL rising and SCL falling, plus the resolved SDA level. The block returns a request to pull SDA low. After reset the alert line is held low for a fixed power-up window so the host sees that the device is alive. Pin changes that happen inside that window are not latched.

Top module: `alert_latch_arb`

## Requirements
- R1: After reset release, alertN is held low for PWRUP_CYCLES clocks and then goes high if nothing is pending. Pin level changes inside that window are never latched.
- R2: A change of level on pin input k sets the latch when the active mask bit k is 0. alertN then goes low within SYNC_STAGES+2 clocks.
- R3: An active mask bit of 1 suppresses the change interrupt of its pin. The active mask is normMask when suspendN is 1 and suspMask when suspendN is 0.
- R4: A thermal fault sets the latch whatever the masks hold, and a one-cycle pulse is enough.
- R5: The latch keeps alertN low after its cause has gone away, until the latch is cleared.
- R6: A read of the alert-response address is the byte 0x19: the seven bits 0001100, MSB first, then a read bit of 1. When the latch is set, this block pulls SDA low during the ninth clock as acknowledge. It then sends its own 7-bit address, MSB first, followed by a 1 bit.
- R7: This block never pulls SDA low when nothing is pending, or when the read uses any other address.
- R8: Suppose this block releases SDA for a 1 bit and samples SDA low at SCL rising. It then stops driving for the rest of the transfer, and the latch stays set.
- R9: When all eight transmitted bits pass without a loss, the latch clears at the SCL rise of the eighth bit and alertN goes high.
- R10: A stop strobe aborts any transfer that is under way. A start strobe restarts address reception, so a partial transfer has no effect on the latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| pinIn | input | NPINS | Pin input levels (asynchronous) |
| thermFault | input | 1 | Thermal fault flag, active high |
| suspendN | input | 1 | 1 selects normMask, 0 selects suspMask |
| normMask | input | NPINS | Per-pin masks of the normal register, 1 masks |
| suspMask | input | NPINS | Per-pin masks of the suspend register, 1 masks |
| ownAddr | input | 7 | This device's bus address |
| startSeen | input | 1 | One-cycle strobe: start condition |
| stopSeen | input | 1 | One-cycle strobe: stop condition |
| sclRise | input | 1 | One-cycle strobe: SCL rising edge |
| sclFall | input | 1 | One-cycle strobe: SCL falling edge |
| sdaIn | input | 1 | Resolved SDA bus level |
| sdaDrvLow | output | 1 | Request to pull SDA low |
| alertN | output | 1 | Active-low alert output |

## Verification
The bench builds the block with NPINS=3, SYNC_STAGES=2 and PWRUP_CYCLES=20. With 20 clocks, the expiry of the power-up window and a pin pulse inside it fall into a short run. With three pins, each mask bit of both mask sets can be the one that matters. A rival responder on the modelled wired-AND bus is given an address that is lower or higher than the block's own, which drives both the losing and the winning arbitration paths.

// File: rtl/alert_arb_pkg.sv
package alert_arb_pkg;

  localparam logic [6:0] RESP_ADDR = 7'b0001100;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_DONE
  } arbState_t;

  typedef struct packed {
    logic clrCnt;
    logic incCnt;
    logic capRx;
    logic loadTx;
    logic shiftTx;
    logic clrLatch;
  } arbStrobe_t;

endpackage

// File: rtl/alert_arb_dp.sv
module alert_arb_dp
  import alert_arb_pkg::*;
#(
  parameter int NPINS        = 3,
  parameter int SYNC_STAGES  = 2,
  parameter int PWRUP_CYCLES = 1000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [NPINS-1:0] pinIn,
  input  logic             thermFault,
  input  logic             suspendN,
  input  logic [NPINS-1:0] normMask,
  input  logic [NPINS-1:0] suspMask,
  input  logic [6:0]       ownAddr,
  input  logic             sdaIn,
  input  arbStrobe_t       strb,
  output logic [7:0]       rxByte,
  output logic [3:0]       bitCount,
  output logic             txMsb,
  output logic             pending,
  output logic             pwrDone
);

  localparam int PW = $clog2(PWRUP_CYCLES + 1);

  logic [NPINS-1:0] syncStage [SYNC_STAGES];
  logic [NPINS-1:0] prevPins;
  logic [NPINS-1:0] activeMask;
  logic [NPINS-1:0] pinChange;
  logic [PW-1:0]    pwrCnt;
  logic [7:0]       txShift;
  logic             setLatch;

  // Synchroniser chain for the pin inputs
  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rstN) syncStage[0] <= '0;
        else       syncStage[0] <= pinIn;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rstN) syncStage[s] <= '0;
        else       syncStage[s] <= syncStage[s-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) prevPins <= '0;
    else       prevPins <= syncStage[SYNC_STAGES-1];
  end

  always_ff @(posedge clk) begin
    if (!rstN)                        pwrCnt <= '0;
    else if (pwrCnt != PW'(PWRUP_CYCLES)) pwrCnt <= pwrCnt + 1'b1;
  end

  assign pwrDone    = (pwrCnt == PW'(PWRUP_CYCLES));
  assign activeMask = suspendN ? normMask : suspMask;
  assign pinChange  = (syncStage[SYNC_STAGES-1] ^ prevPins) & ~activeMask;
  assign setLatch   = thermFault | (pwrDone & (|pinChange));

  always_ff @(posedge clk) begin
    if (!rstN)              pending <= 1'b0;
    else if (setLatch)      pending <= 1'b1;
    else if (strb.clrLatch) pending <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxByte   <= '0;
      bitCount <= '0;
      txShift  <= '1;
    end else begin
      if (strb.capRx)       rxByte <= {rxByte[6:0], sdaIn};
      if (strb.clrCnt)      bitCount <= '0;
      else if (strb.incCnt) bitCount <= bitCount + 1'b1;
      if (strb.loadTx)       txShift <= {ownAddr, 1'b1};
      else if (strb.shiftTx) txShift <= {txShift[6:0], 1'b1};
    end
  end

  assign txMsb = txShift[7];

  AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (pending && !strb.clrLatch) |=> pending); // R5
  AST_THERM_SETS: assert property (@(posedge clk) disable iff (!rstN)
    thermFault |=> pending); // R4
  AST_PWRUP_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (!pwrDone && !thermFault && !pending) |=> !pending); // R1

endmodule

// File: rtl/alert_arb_ctrl.sv
module alert_arb_ctrl
  import alert_arb_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startSeen,
  input  logic       stopSeen,
  input  logic       sclRise,
  input  logic       sclFall,
  input  logic       sdaIn,
  input  logic [7:0] rxByte,
  input  logic [3:0] bitCount,
  input  logic       txMsb,
  input  logic       pending,
  output arbStrobe_t strb,
  output logic       sdaDrvLow
);

  arbState_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    strb      = '0;
    if (stopSeen) begin
      nextState = ST_IDLE;
    end else if (startSeen) begin
      nextState   = ST_RX;
      strb.clrCnt = 1'b1;
    end else begin
      unique case (state)
        ST_RX: begin
          if (sclRise) begin
            strb.capRx  = 1'b1;
            strb.incCnt = 1'b1;
          end else if (sclFall && bitCount == 4'd8) begin
            if (rxByte == {RESP_ADDR, 1'b1} && pending) nextState = ST_ACK;
            else                                        nextState = ST_DONE;
          end
        end
        ST_ACK: begin
          if (sclFall) begin
            nextState   = ST_TX;
            strb.loadTx = 1'b1;
            strb.clrCnt = 1'b1;
          end
        end
        ST_TX: begin
          if (sclRise) begin
            if (txMsb && !sdaIn) begin
              nextState = ST_DONE;
            end else begin
              strb.incCnt = 1'b1;
              if (bitCount == 4'd7) begin
                strb.clrLatch = 1'b1;
                nextState     = ST_DONE;
              end
            end
          end else if (sclFall) begin
            strb.shiftTx = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign sdaDrvLow = (state == ST_ACK) || (state == ST_TX && !txMsb);

  AST_DRIVE_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rstN)
    sdaDrvLow |-> pending); // R7
  AST_CLEAR_AFTER_TX: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pending) |-> ($past(state) == ST_TX && $past(sclRise))); // R9
  AST_LOSS_RELEASES: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_TX && sclRise && !startSeen && !stopSeen && txMsb && !sdaIn)
      |=> (!sdaDrvLow && pending)); // R8

endmodule

// File: rtl/alert_latch_arb.sv
module alert_latch_arb
  import alert_arb_pkg::*;
#(
  parameter int NPINS        = 3,
  parameter int SYNC_STAGES  = 2,
  parameter int PWRUP_CYCLES = 1000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [NPINS-1:0] pinIn,
  input  logic             thermFault,
  input  logic             suspendN,
  input  logic [NPINS-1:0] normMask,
  input  logic [NPINS-1:0] suspMask,
  input  logic [6:0]       ownAddr,
  input  logic             startSeen,
  input  logic             stopSeen,
  input  logic             sclRise,
  input  logic             sclFall,
  input  logic             sdaIn,
  output logic             sdaDrvLow,
  output logic             alertN
);

  arbStrobe_t strb;
  logic [7:0] rxByte;
  logic [3:0] bitCount;
  logic       txMsb;
  logic       pending;
  logic       pwrDone;

  alert_arb_dp #(
    .NPINS(NPINS), .SYNC_STAGES(SYNC_STAGES), .PWRUP_CYCLES(PWRUP_CYCLES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .thermFault(thermFault),
    .suspendN(suspendN), .normMask(normMask), .suspMask(suspMask),
    .ownAddr(ownAddr), .sdaIn(sdaIn), .strb(strb), .rxByte(rxByte),
    .bitCount(bitCount), .txMsb(txMsb), .pending(pending), .pwrDone(pwrDone)
  );

  alert_arb_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .startSeen(startSeen), .stopSeen(stopSeen),
    .sclRise(sclRise), .sclFall(sclFall), .sdaIn(sdaIn), .rxByte(rxByte),
    .bitCount(bitCount), .txMsb(txMsb), .pending(pending), .strb(strb),
    .sdaDrvLow(sdaDrvLow)
  );

  assign alertN = !(pending || !pwrDone);

  AST_ALERT_LOW_WHEN_PENDING: assert property (@(posedge clk) disable iff (!rstN)
    pending |-> !alertN); // R5

endmodule

// File: tb/alert_latch_arb_bench.sv
module alert_latch_arb_bench;

  localparam int NPINS = 3;
  localparam int PWRUP = 20;
  localparam logic [6:0] OWN = 7'h21;
  localparam logic [6:0] ARA = 7'b0001100;

  // {pins, normMask, suspMask, suspendN, expectAlert}
  localparam logic [10:0] VEC [8] = '{
    {3'b001, 3'b000, 3'b000, 1'b1, 1'b1},
    {3'b011, 3'b010, 3'b000, 1'b1, 1'b0},
    {3'b111, 3'b011, 3'b000, 1'b1, 1'b1},
    {3'b110, 3'b110, 3'b000, 1'b1, 1'b1},
    {3'b100, 3'b111, 3'b000, 1'b1, 1'b0},
    {3'b101, 3'b111, 3'b000, 1'b0, 1'b1},
    {3'b001, 3'b000, 3'b100, 1'b0, 1'b0},
    {3'b000, 3'b000, 3'b000, 1'b1, 1'b1}
  };

  logic clk = 0;
  logic rstN = 0;
  logic [NPINS-1:0] pinIn = '0, normMask = '1, suspMask = '1;
  logic thermFault = 0, suspendN = 1;
  logic startSeen = 0, stopSeen = 0, sclRise = 0, sclFall = 0;
  logic masterSda = 1, rivalLow = 0;
  logic sdaBus, sdaDrvLow, alertN;
  int checks = 0, errors = 0;
  logic done = 0;

  always #2 clk = ~clk;

  assign sdaBus = masterSda & ~sdaDrvLow & ~rivalLow;

  alert_latch_arb #(.NPINS(NPINS), .SYNC_STAGES(2), .PWRUP_CYCLES(PWRUP)) u_alert_latch_arb (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .thermFault(thermFault),
    .suspendN(suspendN), .normMask(normMask), .suspMask(suspMask),
    .ownAddr(OWN), .startSeen(startSeen), .stopSeen(stopSeen),
    .sclRise(sclRise), .sclFall(sclFall), .sdaIn(sdaBus),
    .sdaDrvLow(sdaDrvLow), .alertN(alertN)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulseStart();
    @(negedge clk); startSeen = 1;
    @(negedge clk); startSeen = 0;
  endtask

  task automatic pulseStop();
    @(negedge clk); masterSda = 1; stopSeen = 1;
    @(negedge clk); stopSeen = 0;
  endtask

  task automatic busBit(input logic v, output logic seen);
    masterSda = v;
    @(negedge clk); seen = sdaBus; sclRise = 1;
    @(negedge clk); sclRise = 0;
    @(negedge clk); sclFall = 1;
    @(negedge clk); sclFall = 0;
    @(negedge clk);
  endtask

  task automatic readAddr(input logic [6:0] addr, input logic useRival,
                          input logic [6:0] rivalAddr,
                          output logic acked, output logic [7:0] got);
    logic s;
    logic rivalLost;
    logic [7:0] hdr;
    logic [7:0] rb;
    hdr = {addr, 1'b1};
    rb = {rivalAddr, 1'b1};
    rivalLost = 0;
    pulseStart();
    for (int i = 7; i >= 0; i--) busBit(hdr[i], s);
    rivalLow = useRival;
    busBit(1'b1, s);
    acked = !s;
    for (int i = 7; i >= 0; i--) begin
      rivalLow = useRival & ~rivalLost & ~rb[i];
      busBit(1'b1, s);
      got[i] = s;
      if (rb[i] && !s) rivalLost = 1;
    end
    rivalLow = 0;
    busBit(1'b1, s);
    pulseStop();
  endtask

  initial begin
    logic ack;
    logic [7:0] got;
    logic s;
    waitCyc(3);
    rstN = 1;
    waitCyc(2);
    chk("R1 alert low in power-up window", alertN, 0);
    pinIn = 3'b001; normMask = '0;
    waitCyc(4);
    pinIn = 3'b000;
    waitCyc(PWRUP + 6);
    chk("R1 alert high after window", alertN, 1);
    readAddr(ARA, 0, 7'h0, ack, got);
    chk("R7 no ack when idle", ack, 0);
    chk("R7 bus untouched when idle", got, 8'hFF);

    for (int i = 0; i < 8; i++) begin
      logic [10:0] v;
      v = VEC[i];
      normMask = v[7:5]; suspMask = v[4:2]; suspendN = v[1];
      waitCyc(2);
      pinIn = v[10:8];
      waitCyc(8);
      chk("R2/R3 vector alert level", alertN, !v[0]);
      readAddr(ARA, 0, 7'h0, ack, got);
      if (v[0]) begin
        chk("R6 ack on response read", ack, 1);
        chk("R6 own address sent", got, {OWN, 1'b1});
        waitCyc(2);
        chk("R9 alert released after win", alertN, 1);
      end else begin
        chk("R7 no ack for masked change", ack, 0);
        chk("R3 latch not set", alertN, 1);
      end
    end

    // R5: cause vanishes, alert stays
    normMask = '0; suspendN = 1;
    pinIn = 3'b010; waitCyc(4); pinIn = 3'b000;
    waitCyc(20);
    chk("R5 alert stays latched", alertN, 0);

    // R10: stop aborts a partial transfer, start restarts reception
    pulseStart();
    busBit(0, s); busBit(0, s); busBit(0, s);
    pulseStop();
    chk("R10 abort by stop keeps latch", alertN, 0);
    chk("R10 no drive after abort", sdaDrvLow, 0);
    pulseStart();
    busBit(0, s); busBit(1, s);

    // R7: other address is ignored
    readAddr(OWN, 0, 7'h0, ack, got);
    chk("R7 other address not acked", ack, 0);
    chk("R7 other address no data", got, 8'hFF);

    // R8: lower rival wins
    readAddr(ARA, 1, 7'h05, ack, got);
    chk("R8 bus carries rival address", got, {7'h05, 1'b1});
    chk("R8 alert kept after loss", alertN, 0);
    chk("R8 released after loss", sdaDrvLow, 0);

    // R9: higher rival loses
    readAddr(ARA, 1, 7'h7E, ack, got);
    chk("R9 own address wins", got, {OWN, 1'b1});
    waitCyc(1);
    chk("R9 alert cleared on win", alertN, 1);

    // R4: thermal fault with all masks set
    normMask = '1; suspMask = '1;
    @(negedge clk); thermFault = 1;
    @(negedge clk); thermFault = 0;
    waitCyc(2);
    chk("R4 thermal fault latched", alertN, 0);
    readAddr(ARA, 0, 7'h0, ack, got);
    chk("R4 thermal cleared by response", alertN, 1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule